// File: doc/BRIEF.md
# Masked Vector Lane Writeback with Broadcast

This block assembles the destination register of a packed vector operation whose elements are 64 bits wide. It presents an operand vector to an external per-lane function unit, either the register source as given or a single 64-bit memory element replicated into every lane. It then merges the unit's per-lane results into a new full 512-bit destination, under an 8-bit per-lane mask. Lanes the mask leaves out either keep the old destination contents or are forced to zero. Every bit above the active vector length is cleared.

The operand path to the lane unit is combinational, and the lane unit returns its results in the same cycle. The destination is captured on the clock edge at which `inValid` is high and is held until the next accepted operation. A vector-length select picks 2, 4 or 8 active lanes, which is 128, 256 or 512 bits.

Top module: `vec_lane_wb`

## Requirements
- R1: `vlSel` sets the active lane count: 0 selects 2 lanes (128 bits), 1 selects 4 lanes (256 bits), and 2 or 3 select 8 lanes (512 bits). Lane j occupies bits [64j+63:64j].
- R2: When `srcIsMem` is 1, every 64-bit lane of `laneSrc` equals `memElem`. When it is 0, `laneSrc` equals `srcVec`.
- R3: An active lane j is written with lane j of `laneRes` when `laneMask[j]` is 1, or when `noMask` is 1 whatever the mask holds.
- R4: With `zeroMask` at 0 (merging), an active lane that is not selected takes lane j of `oldDest`.
- R5: With `zeroMask` at 1 (zeroing), an active lane that is not selected is written with zero.
- R6: All destination bits from the active vector length up to bit 511 are zero, whatever the mask, the results and the old contents hold.
- R7: Mask bits at or above the active lane count have no effect on `dest`.
- R8: `dest` and `destValid` update on the clock edge at which `inValid` is 1. After an edge at which `inValid` is 0, `destValid` is 0 and `dest` keeps its value.
- R9: While `rstN` is low, `dest` is zero and `destValid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operation present this cycle |
| srcIsMem | input | 1 | 1: broadcast memElem, 0: use srcVec |
| srcVec | input | 512 | Register source vector |
| memElem | input | 64 | Memory element to broadcast |
| laneSrc | output | 512 | Operand vector sent to the lane unit |
| laneRes | input | 512 | Per-lane results returned by the lane unit |
| laneMask | input | 8 | Per-lane write mask, bit j for lane j |
| noMask | input | 1 | 1: write all active lanes, ignoring laneMask |
| zeroMask | input | 1 | 1: zeroing, 0: merging for unselected lanes |
| vlSel | input | 2 | Vector length select |
| oldDest | input | 512 | Previous destination contents |
| dest | output | 512 | New destination |
| destValid | output | 1 | dest was updated at the last edge |

## Verification
The bench drives each vector length with both masking styles and both source kinds, using scattered masks. A design that clipped at the wrong lane would show old or result data above 128 or 256 bits, or lose the top active lane. Masks with bits set above the active lane count catch a design that lets them re-enable cleared lanes. Cases with `noMask` set and an all-zero mask catch a design that still honours the mask. Merge-versus-zero cases with distinct old contents show a swapped polarity as zeros where old data belongs. Broadcast cases check every lane of the operand, which exposes a design that replicates only into lane 0. A hold case with changed inputs and `inValid` low catches a design whose destination register loads without a valid operation.

// File: rtl/vlwb_pkg.sv
package vlwb_pkg;
  localparam int LANE_W    = 64;
  localparam int MAX_LANES = 8;
  localparam int VEC_W     = LANE_W * MAX_LANES;
  localparam int VL_W      = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic                 load;
    logic [MAX_LANES-1:0] takeRes;
    logic [MAX_LANES-1:0] keepOld;
  } wbStrobe_t;
endpackage

// File: rtl/vlwb_ctrl.sv
module vlwb_ctrl
  import vlwb_pkg::*;
(
  input  logic                 inValid,
  input  logic [MAX_LANES-1:0] laneMask,
  input  logic                 noMask,
  input  logic                 zeroMask,
  input  logic [VL_W-1:0]      vlSel,
  output wbStrobe_t            strb
);
  localparam int CNT_W = $clog2(MAX_LANES + 1);

  logic [CNT_W-1:0]     activeLanes;
  logic [MAX_LANES-1:0] laneOn;

  // 0 -> 2 lanes, 1 -> 4 lanes, 2/3 -> all lanes
  always_comb begin
    case (vlSel)
      2'd0:    activeLanes = CNT_W'(MAX_LANES / 4);
      2'd1:    activeLanes = CNT_W'(MAX_LANES / 2);
      default: activeLanes = CNT_W'(MAX_LANES);
    endcase
  end

  for (genvar j = 0; j < MAX_LANES; j++) begin : g_lane
    assign laneOn[j]       = (CNT_W'(j) < activeLanes);
    assign strb.takeRes[j] = laneOn[j] & (noMask | laneMask[j]);
    assign strb.keepOld[j] = laneOn[j] & ~(noMask | laneMask[j]) & ~zeroMask;
  end

  assign strb.load = inValid;
endmodule

// File: rtl/vlwb_dp.sv
module vlwb_dp
  import vlwb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  wbStrobe_t         strb,
  input  logic              srcIsMem,
  input  logic [VEC_W-1:0]  srcVec,
  input  logic [LANE_W-1:0] memElem,
  input  logic [VEC_W-1:0]  laneRes,
  input  logic [VEC_W-1:0]  oldDest,
  output logic [VEC_W-1:0]  laneSrc,
  output logic [VEC_W-1:0]  dest,
  output logic              destValid
);
  logic [VEC_W-1:0] nextDest;

  for (genvar j = 0; j < MAX_LANES; j++) begin : g_lane
    localparam int LO = j * LANE_W;
    // operand: broadcast or register lane
    assign laneSrc[LO +: LANE_W] = srcIsMem ? memElem : srcVec[LO +: LANE_W];
    // result, old contents, or zero (inactive / zeroing)
    always_comb begin
      if (strb.takeRes[j])      nextDest[LO +: LANE_W] = laneRes[LO +: LANE_W];
      else if (strb.keepOld[j]) nextDest[LO +: LANE_W] = oldDest[LO +: LANE_W];
      else                      nextDest[LO +: LANE_W] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dest      <= '0;
      destValid <= 1'b0;
    end else begin
      destValid <= strb.load;
      if (strb.load) dest <= nextDest;
    end
  end

  AST_BCAST_TOP: assert property (@(posedge clk) disable iff (!rstN)
    srcIsMem |-> laneSrc[VEC_W-1 -: LANE_W] == memElem); // R2
  AST_VALID_SET: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> destValid); // R8
  AST_VALID_CLR: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> !destValid); // R8
  AST_DEST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> $stable(dest)); // R8
endmodule

// File: rtl/vec_lane_wb.sv
module vec_lane_wb
  import vlwb_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic                 srcIsMem,
  input  logic [VEC_W-1:0]     srcVec,
  input  logic [LANE_W-1:0]    memElem,
  output logic [VEC_W-1:0]     laneSrc,
  input  logic [VEC_W-1:0]     laneRes,
  input  logic [MAX_LANES-1:0] laneMask,
  input  logic                 noMask,
  input  logic                 zeroMask,
  input  logic [VL_W-1:0]      vlSel,
  input  logic [VEC_W-1:0]     oldDest,
  output logic [VEC_W-1:0]     dest,
  output logic                 destValid
);
  wbStrobe_t strb;

  vlwb_ctrl u_ctrl (
    .inValid (inValid),
    .laneMask(laneMask),
    .noMask  (noMask),
    .zeroMask(zeroMask),
    .vlSel   (vlSel),
    .strb    (strb)
  );

  vlwb_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .srcIsMem (srcIsMem),
    .srcVec   (srcVec),
    .memElem  (memElem),
    .laneRes  (laneRes),
    .oldDest  (oldDest),
    .laneSrc  (laneSrc),
    .dest     (dest),
    .destValid(destValid)
  );

  localparam int HALF = VEC_W / 2;
  localparam int QTR  = VEC_W / 4;

  AST_VL_SHORT_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    inValid && vlSel == 2'd0 |=> dest[VEC_W-1:QTR] == '0); // R6
  AST_VL_MID_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    inValid && vlSel == 2'd1 |=> dest[VEC_W-1:HALF] == '0); // R6
  AST_NOMASK_FULL: assert property (@(posedge clk) disable iff (!rstN)
    inValid && noMask && vlSel[1] |=> dest == $past(laneRes)); // R3
  AST_ZERO_LANE0: assert property (@(posedge clk) disable iff (!rstN)
    inValid && zeroMask && !noMask && !laneMask[0] |=> dest[LANE_W-1:0] == '0); // R5
  AST_MERGE_LANE0: assert property (@(posedge clk) disable iff (!rstN)
    inValid && !zeroMask && !noMask && !laneMask[0]
      |=> dest[LANE_W-1:0] == $past(oldDest[LANE_W-1:0])); // R4
endmodule

// File: tb/tb_vec_lane_wb.sv
`timescale 1ns/1ps
module tb_vec_lane_wb;
  localparam int LW = 64;
  localparam int NL = 8;
  localparam int VW = LW * NL;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inValid = 1'b0, srcIsMem = 1'b0, noMask = 1'b0, zeroMask = 1'b0;
  logic [VW-1:0] srcVec = '0, oldDest = '0, laneSrc, laneRes, dest;
  logic [LW-1:0] memElem = '0;
  logic [NL-1:0] laneMask = '0;
  logic [1:0]    vlSel = 2'd0;
  logic          destValid;

  int nVec = 0;
  int nBad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  // lane unit stub: pass-through
  assign laneRes = laneSrc;

  vec_lane_wb dut (.*);

  // {srcIsMem, zeroMask, noMask, vlSel[1:0], laneMask[7:0]}
  localparam logic [12:0] TBL [16] = '{
    13'b0_0_0_00_00000001, 13'b0_1_0_00_00000010, 13'b1_0_0_00_11111110,
    13'b1_1_1_00_00000000, 13'b0_0_0_01_00000101, 13'b0_1_0_01_00001010,
    13'b1_0_0_01_11110110, 13'b1_1_0_01_10011001, 13'b0_0_0_10_10100101,
    13'b0_1_0_10_01011010, 13'b1_0_0_10_10000001, 13'b1_1_0_10_01111110,
    13'b0_0_1_10_00000000, 13'b0_1_0_11_11000011, 13'b1_0_1_11_00110000,
    13'b0_1_1_01_11110000
  };

  function automatic logic [VW-1:0] mkVec(int seed);
    logic [VW-1:0] v;
    for (int j = 0; j < NL; j++)
      v[j*LW +: LW] = 64'h9E37_79B9_7F4A_7C15 * 64'(seed * NL + j + 1) ^ 64'(seed);
    return v;
  endfunction

  // reference: independent of the RTL structure
  function automatic logic [VW-1:0] model(logic mem, logic zr, logic nm, logic [1:0] vl,
                                          logic [NL-1:0] msk, logic [VW-1:0] src,
                                          logic [LW-1:0] me, logic [VW-1:0] old);
    logic [VW-1:0] r;
    int lanes;
    lanes = (vl == 2'd0) ? 2 : (vl == 2'd1) ? 4 : 8;
    for (int j = 0; j < NL; j++) begin
      if (j >= lanes)          r[j*LW +: LW] = '0;
      else if (nm || msk[j])   r[j*LW +: LW] = mem ? me : src[j*LW +: LW];
      else if (zr)             r[j*LW +: LW] = '0;
      else                     r[j*LW +: LW] = old[j*LW +: LW];
    end
    return r;
  endfunction

  task automatic check(string req, logic [VW-1:0] act, logic [VW-1:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [VW-1:0] bcastOf(logic [LW-1:0] e);
    return {NL{e}};
  endfunction

  // drive one op at a negedge, check operand, then result after the edge
  task automatic runOp(logic [12:0] cfg, int seed, string req);
    logic [VW-1:0] exp;
    @(negedge clk);
    {srcIsMem, zeroMask, noMask, vlSel, laneMask} = cfg;
    srcVec  = mkVec(seed);
    oldDest = mkVec(seed + 1000);
    memElem = 64'hA5A5_0000_0000_0000 ^ 64'(seed * 77);
    inValid = 1'b1;
    #1;
    check("R2 operand", laneSrc, srcIsMem ? bcastOf(memElem) : srcVec);
    exp = model(srcIsMem, zeroMask, noMask, vlSel, laneMask, srcVec, memElem, oldDest);
    @(negedge clk);
    inValid = 1'b0;
    check(req, dest, exp);
    check("R8 valid", VW'(destValid), VW'(1));
  endtask

  initial begin
    logic [VW-1:0] held;
    repeat (3) @(negedge clk);
    check("R9 reset dest", dest, '0);
    check("R9 reset valid", VW'(destValid), '0);
    rstN = 1'b1;

    // table walk: R1 R3 R4 R5 R6 R7
    for (int i = 0; i < 16; i++)
      runOp(TBL[i], i + 1, "R1 R3 R4 R5 R6 R7 table");

    // sweep: every length, both masking styles, both sources
    for (int vl = 0; vl < 4; vl++)
      for (int zr = 0; zr < 2; zr++)
        for (int mem = 0; mem < 2; mem++)
          runOp({mem[0], zr[0], 1'b0, vl[1:0], 8'(37 * (vl * 4 + zr * 2 + mem) + 91)},
                100 + vl * 4 + zr * 2 + mem, "R1 R3 R4 R5 R6 sweep");

    // R7: mask bits above two lanes must not reopen cleared lanes
    runOp({1'b0, 1'b0, 1'b0, 2'd0, 8'hFC}, 300, "R7 upper mask ignored");
    // R3: noMask overrides an all-zero mask at full length
    runOp({1'b0, 1'b1, 1'b1, 2'd2, 8'h00}, 301, "R3 noMask");
    // R5: zeroing with empty mask gives all zero
    runOp({1'b1, 1'b1, 1'b0, 2'd3, 8'h00}, 302, "R5 all zeroed");
    // R4: merging with empty mask at 256 bits
    runOp({1'b0, 1'b0, 1'b0, 2'd1, 8'hF0}, 303, "R4 merge old");

    // R8: hold with inValid low and changed inputs
    held = dest;
    @(negedge clk);
    srcVec = mkVec(999); oldDest = mkVec(998); noMask = 1'b1; vlSel = 2'd2;
    @(negedge clk);
    check("R8 hold dest", dest, held);
    check("R8 valid low", VW'(destValid), '0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    #100us;
    if (!done) begin
      nVec++;
      nBad++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end
endmodule